// File: doc/BRIEF.md
# Latched Power-Event Interrupt Bank

This block watches eight power-related input lines and remembers any of them that reaches its active level, even for a short time. Each line has a sticky flag. An input at its active level sets the flag asynchronously, so an event is recorded even while the bus clock is stopped. Each flag then passes through a two-stage synchroniser into the bus clock domain. Software can read it from there.

A small register interface runs on the bus clock. Software uses it to pick the active level of each line, enable each line onto the interrupt, read the raw and the enabled flags, and clear flags by writing ones. The interrupt output is a single line, high while any enabled flag is set. Detection works on levels only. A clear written while the input is still active does not stick, because the flag sets again at once.

Top module: `pwr_evt_bank`

## Requirements
- R1: After a synchronous active-low reset with all inputs inactive, every readable register returns 0 and `irq` is low.
- R2: The enable register (offset 0x00), the polarity register (0x10) and the spare mode register (0x14) each store the 8-bit value written and return it on read. Bit n belongs to channel n.
- R3: An input at its active level sets that channel's flag. The flag reads as 1 in the raw register (0x04) within three bus clock cycles. It stays 1 after the input becomes inactive again.
- R4: A polarity bit of 0 makes the channel active-high, and a polarity bit of 1 makes it active-low.
- R5: An event that occurs while the bus clock is stopped is recorded. It becomes readable in the raw register once the clock runs again.
- R6: Writing to the clear register (0x0C) clears each flag whose data bit is 1 and leaves the other flags unchanged. The clear register reads as 0.
- R7: A flag that is cleared while its input is still at the active level is set again and stays set.
- R8: The pending register (0x08) returns the raw flags ANDed with the enable register. Writes to 0x04 and 0x08 change nothing.
- R9: `irq` is high exactly when the pending register is nonzero.
- R10: The spare mode register has no effect on detection or on the interrupt.
- R11: Reads from unmapped offsets return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; may be stopped |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_in | input | 8 | Power-event input lines, one per channel |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Combined interrupt, OR of the enabled flags |

## Verification
On every clock edge, the assertions check four things. An active input leaves its flag set in the next cycle, even when a clear arrives in the same cycle. A set flag stays set unless a clear arrives. A synchronised flag rises only two cycles after the flag itself. Configuration changes only on a write, and the interrupt is never raised with all enables off. Some behaviours are visible only in the bench's scenarios: capture while the clock is stopped, the polarity sweep over every channel, the pending and interrupt results for all 256 enable patterns, the ignored writes, and the spare register having no effect.

// File: rtl/pwr_evt_pkg.sv
// Package: register offsets and bus widths shared by the power-event bank.
// Assumes byte-addressed 32-bit-aligned registers decoded on 5 address bits.
package pwr_evt_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_ENABLE  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_RAWFLAG = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_PENDING = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CLEAR   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_POLAR   = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_SPARE   = 5'h14;
endpackage

// File: rtl/pwr_evt_capture.sv
// Module: per-channel sticky event capture with asynchronous set and
// a two-stage synchroniser into the bus clock domain.
// Assumes: clr is a single-cycle pulse synchronous to clk; the active
// level (input XOR polarity) dominates clear and reset.
module pwr_evt_capture #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ev_in,
    input  logic [NCH-1:0] pol,
    input  logic [NCH-1:0] clr,
    output logic [NCH-1:0] raw_sync
);
    logic [NCH-1:0] trig;
    logic [NCH-1:0] flag;
    logic [NCH-1:0] meta_q;

    // Active level per channel: polarity 1 inverts the input.
    assign trig = ev_in ^ pol;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic flag_q;

        // Sticky flag: set without a clock, cleared on the bus clock.
        always_ff @(posedge clk or posedge trig[i]) begin
            if (trig[i])
                flag_q <= 1'b1;
            else if (!rst_n)
                flag_q <= 1'b0;
            else if (clr[i])
                flag_q <= 1'b0;
        end

        assign flag[i] = flag_q;

        // R7: an active level at a clock edge leaves the flag set afterwards.
        p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
            trig[i] |=> flag[i]);

        // R3: a set flag only falls on a clear request.
        p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[i] && !clr[i]) |=> flag[i]);
    end

    // Two-stage synchroniser bringing flags into the bus domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            raw_sync <= '0;
        end else begin
            meta_q   <= flag;
            raw_sync <= meta_q;
        end
    end

    // R3: a synchronised flag rises only after the flag was set two cycles back.
    for (genvar k = 0; k < NCH; k++) begin : g_chk
        p_sync_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(raw_sync[k]) |-> $past(flag[k], 2));
    end
endmodule

// File: rtl/pwr_evt_cfg.sv
// Module: configuration storage (enable, polarity, spare mode) and
// decode of write-one-to-clear requests.
// Assumes writes complete in one cycle; unmapped writes are dropped.
module pwr_evt_cfg
    import pwr_evt_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NCH-1:0]    bus_wdata,
    output logic [NCH-1:0]    en_q,
    output logic [NCH-1:0]    pol_q,
    output logic [NCH-1:0]    mode_q,
    output logic [NCH-1:0]    clr
);
    logic wr_en, wr_pol, wr_mode;

    // Address decode of the writable storage registers.
    assign wr_en   = bus_wr && (bus_addr == OFS_ENABLE);
    assign wr_pol  = bus_wr && (bus_addr == OFS_POLAR);
    assign wr_mode = bus_wr && (bus_addr == OFS_SPARE);

    // Clear pulse: one bit per channel, only in the write cycle.
    assign clr = (bus_wr && (bus_addr == OFS_CLEAR)) ? bus_wdata : '0;

    // Storage update for the three read/write registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pol_q  <= '0;
            mode_q <= '0;
        end else begin
            if (wr_en)   en_q   <= bus_wdata;
            if (wr_pol)  pol_q  <= bus_wdata;
            if (wr_mode) mode_q <= bus_wdata;
        end
    end

    // R2: configuration only changes in response to a bus write.
    p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(en_q) && $stable(pol_q));

    // R11: a write to an unmapped offset changes no configuration.
    p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr > OFS_SPARE) |=> $stable(en_q) && $stable(pol_q) && $stable(mode_q));
endmodule

// File: rtl/pwr_evt_bank.sv
// Module: top of the latched power-event bank. Joins configuration,
// capture and the read multiplexer, and drives the combined interrupt.
// Assumes reads are combinational on bus_addr; no read side effects.
module pwr_evt_bank
    import pwr_evt_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    ev_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NCH-1:0]    bus_wdata,
    output logic [NCH-1:0]    bus_rdata,
    output logic              irq
);
    logic [NCH-1:0] en_q, pol_q, mode_q, clr, raw_sync, pend;

    pwr_evt_cfg #(.NCH(NCH)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .en_q     (en_q),
        .pol_q    (pol_q),
        .mode_q   (mode_q),
        .clr      (clr)
    );

    pwr_evt_capture #(.NCH(NCH)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_in   (ev_in),
        .pol     (pol_q),
        .clr     (clr),
        .raw_sync(raw_sync)
    );

    // Enabled view of the synchronised flags.
    assign pend = raw_sync & en_q;
    assign irq  = |pend;

    // Read multiplexer; clear and unmapped offsets return zero.
    always_comb begin
        case (bus_addr)
            OFS_ENABLE:  bus_rdata = en_q;
            OFS_RAWFLAG: bus_rdata = raw_sync;
            OFS_PENDING: bus_rdata = pend;
            OFS_POLAR:   bus_rdata = pol_q;
            OFS_SPARE:   bus_rdata = mode_q;
            default:     bus_rdata = '0;
        endcase
    end

    // R9: the interrupt is never raised while every enable is off.
    p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en_q != '0));
endmodule

// File: tb/sim_pwr_evt_bank.sv
module sim_pwr_evt_bank;
    logic       clk = 1'b0;
    logic       clk_run = 1'b1;
    logic       rst_n = 1'b0;
    logic [7:0] ev_in = 8'h00;
    logic       bus_wr = 1'b0;
    logic [4:0] bus_addr = 5'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;
    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    pwr_evt_bank u0 (
        .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // 100 MHz clock that can be held still.
    always begin
        #5;
        if (clk_run) clk = ~clk;
    end

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
    endtask

    initial begin
        logic [7:0] v;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 32; a += 4) begin
            rd(5'(a), v); chk("R1 reset read", v, 8'h00);
        end
        chk("R1 reset irq", {7'd0, irq}, 8'h00);

        // R2: storage registers
        wr(5'h00, 8'hA5); rd(5'h00, v); chk("R2 enable", v, 8'hA5);
        wr(5'h14, 8'h3C); rd(5'h14, v); chk("R2 spare", v, 8'h3C);
        wr(5'h10, 8'h00); rd(5'h10, v); chk("R2 polarity", v, 8'h00);
        wr(5'h00, 8'h00);

        // R3 R4 R6 sweep: each channel, both polarities
        for (int p = 0; p < 2; p++) begin
            logic [7:0] idle;
            idle = p ? 8'hFF : 8'h00;
            ev_in = idle;
            wr(5'h10, idle);
            wr(5'h0C, 8'hFF); settle();
            rd(5'h04, v); chk("R4 idle level no event", v, 8'h00);
            for (int c = 0; c < 8; c++) begin
                ev_in = idle ^ (8'h01 << c);
                settle();
                rd(5'h04, v); chk(p ? "R4 active-low capture" : "R3 active-high capture", v, 8'h01 << c);
                ev_in = idle;
                settle();
                rd(5'h04, v); chk("R3 sticky after release", v, 8'h01 << c);
                wr(5'h0C, 8'h00); settle();
                rd(5'h04, v); chk("R6 zero write keeps flag", v, 8'h01 << c);
                wr(5'h0C, 8'h01 << c); settle();
                rd(5'h04, v); chk("R6 clear", v, 8'h00);
                rd(5'h0C, v); chk("R6 clear reads zero", v, 8'h00);
            end
        end
        wr(5'h10, 8'h00); ev_in = 8'h00; wr(5'h0C, 8'hFF); settle();

        // R5: event while clock stopped
        @(negedge clk); clk_run = 1'b0;
        #50 ev_in = 8'h24;
        #50 ev_in = 8'h00;
        #50 clk_run = 1'b1;
        settle();
        rd(5'h04, v); chk("R5 capture without clock", v, 8'h24);
        wr(5'h0C, 8'hFF); settle();

        // R7: clear while active
        ev_in = 8'h81; settle();
        wr(5'h0C, 8'hFF); settle();
        rd(5'h04, v); chk("R7 re-set while active", v, 8'h81);
        ev_in = 8'h00; wr(5'h0C, 8'hFF); settle();
        rd(5'h04, v); chk("R7 clear after release", v, 8'h00);

        // R8 R9: pending and irq over all enable patterns, with a partial flag set
        ev_in = 8'h5B; settle(); ev_in = 8'h00; settle();
        for (int e = 0; e < 256; e++) begin
            wr(5'h00, 8'(e));
            rd(5'h08, v); chk("R8 pending", v, 8'h5B & 8'(e));
            chk("R9 irq", {7'd0, irq}, {7'd0, |(8'h5B & 8'(e))});
        end
        wr(5'h04, 8'h00); wr(5'h08, 8'h00);
        rd(5'h04, v); chk("R8 raw write ignored", v, 8'h5B);

        // R10: spare register does not alter detection or irq
        wr(5'h14, 8'hFF); wr(5'h00, 8'h00);
        chk("R10 irq off", {7'd0, irq}, 8'h00);
        wr(5'h0C, 8'hFF); ev_in = 8'h10; settle(); ev_in = 8'h00; settle();
        rd(5'h04, v); chk("R10 capture unchanged", v, 8'h10);

        // R11: unmapped offsets
        wr(5'h18, 8'hFF); wr(5'h1C, 8'hFF);
        rd(5'h18, v); chk("R11 unmapped read", v, 8'h00);
        rd(5'h00, v); chk("R11 enable untouched", v, 8'h00);
        rd(5'h10, v); chk("R11 polarity untouched", v, 8'h00);
        rd(5'h14, v); chk("R11 spare untouched", v, 8'hFF);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule